// File: doc/BRIEF.md
# SEC-DED Hamming Encoder and Decoder

This block guards a data word with single-error-correcting, double-error-detecting protection. On the write side a purely combinational encoder turns a data word into a set of Hamming check bits and one overall parity bit. The caller stores all three fields next to each other. On the read side the decoder takes the stored data, check bits and parity bit back in. It recomputes the check bits and XORs them with the stored ones to form a syndrome. From the syndrome and the overall parity it decides whether the word is clean, holds one repairable error, or holds an uncorrectable error.

The check bits belong to code positions that are powers of two (1, 2, 4, ...). Data bits fill the other positions in rising order, so a nonzero syndrome gives the number of the failing position. A correction-enable input lets raw data pass through while the error flags are still reported. Decode results are registered and appear one cycle after a read-valid strobe.

With the default width of 64 data bits the block uses 7 check bits, for a 72-bit stored word.

Top module: `secded_codec`

## Requirements
- R1: The check-bit count is the smallest H with DATA_W + H + 1 <= 2^H. This gives 7 for 64 data bits and 4 for 8 data bits.
- R2: Code positions are numbered from 1. Check bit j (0-based) occupies position 2^j. Data bit i (0-based) occupies the i-th non-power-of-two position, so data bits 0,1,2,3,4 sit at 3,5,6,7,9. Encoder check bit j is the XOR of every data bit whose position has bit j set.
- R3: The encoder parity bit makes the XOR over all data bits, all check bits and the parity bit equal 0. The encoder is combinational.
- R4: A stored word exactly as encoded decodes with both flags low and the data unchanged.
- R5: A single flipped data bit gives sec=1 and ded=0. When correction is enabled the original data is returned.
- R6: A single flipped check bit or a flipped parity bit gives sec=1 and ded=0, with the data passed through unchanged.
- R7: Any two flipped bits give ded=1 and sec=0, and the raw stored data is output. This includes data bits 2 and 5, whose syndrome of 12 points at data bit 7.
- R8: If the syndrome is above DATA_W+H and the parity fails, the decoder reports ded=1 and sec=0 and leaves the data unchanged. Flipping all check bits produces this case.
- R9: With correction disabled, the stored data appears unchanged on the output and the flags still follow R4 to R8.
- R10: The decode outputs and the valid output update on the clock edge that samples dec_vld_i high, and dec_vld_o is dec_vld_i delayed by one cycle. While dec_vld_i is low, the data and flags hold.
- R11: After reset, dec_vld_o, dec_sec_o, dec_ded_o and dec_data_o are all 0.
- R12: dec_sec_o and dec_ded_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | DATA_W | Data word to encode |
| enc_chk_o | output | CHK_W | Generated check bits |
| enc_par_o | output | 1 | Generated overall parity bit |
| dec_vld_i | input | 1 | Read strobe: the stored word is valid this cycle |
| dec_data_i | input | DATA_W | Stored data word |
| dec_chk_i | input | CHK_W | Stored check bits |
| dec_par_i | input | 1 | Stored parity bit |
| dec_cor_en_i | input | 1 | 1: flip the failing data bit; 0: pass raw data |
| dec_vld_o | output | 1 | Decode result valid |
| dec_data_o | output | DATA_W | Corrected or raw data |
| dec_sec_o | output | 1 | Single correctable error seen |
| dec_ded_o | output | 1 | Uncorrectable error seen |

## Verification
In one cycle, the correction path and the double-error classifier can both react to the same syndrome. Flipping data bits 2 and 5 together produces a syndrome that names a real data position (data bit 7), so a correction would alter a bit that was never wrong. The bench applies that pair, and other two-bit pairs, with correction enabled. It judges that ded is set, sec is clear, and the output equals the raw stored word with no extra flip. Each result is compared against a reference built by XORing the positions of the set bits.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // smallest H with dw + H + 1 <= 2^H
  function automatic int unsigned chk_width(int unsigned dw);
    int unsigned h;
    h = 1;
    while ((dw + h + 1) > (32'd1 << h)) h++;
    return h;
  endfunction

  // code position (1-based) of data bit idx: idx-th non-power-of-two >= 3
  function automatic int unsigned data_pos(int unsigned idx);
    int unsigned n;
    int unsigned pos;
    n   = 0;
    pos = 0;
    for (int unsigned p = 3; p < idx + 48; p++) begin
      if (pos == 0 && (p & (p - 1)) != 0) begin
        if (n == idx) pos = p;
        n++;
      end
    end
    return pos;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = secded_pkg::chk_width(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o,
  output logic              par_o
);

  for (genvar j = 0; j < CHK_W; j++) begin : g_chk
    logic [DATA_W-1:0] sel;
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam int unsigned POS = secded_pkg::data_pos(i);
      if (POS[j]) begin : g_use
        assign sel[i] = data_i[i];
      end else begin : g_skip
        assign sel[i] = 1'b0;
      end
    end
    assign chk_o[j] = ^sel;
  end

  assign par_o = (^data_i) ^ (^chk_o);

endmodule

// File: rtl/secded_syn.sv
module secded_syn #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = secded_pkg::chk_width(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  input  logic              par_i,
  output logic [CHK_W-1:0]  syn_o,
  output logic              par_err_o
);

  logic [CHK_W-1:0] regen_chk;
  logic             regen_par;

  secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_regen (
    .data_i (data_i),
    .chk_o  (regen_chk),
    .par_o  (regen_par)
  );

  assign syn_o = regen_chk ^ chk_i;
  // overall parity over the stored word is odd on any odd error count
  assign par_err_o = (^data_i) ^ (^chk_i) ^ par_i;

  always_comb begin
    if (!$isunknown({data_i, chk_i, par_i}))
      // R3: a word without flips yields zero syndrome and good parity
      assert ((syn_o != '0) || par_err_o || (regen_par == par_i)) // R3
        else $error("AST_SYN_PARITY");
  end

endmodule

// File: rtl/secded_fix.sv
module secded_fix #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = secded_pkg::chk_width(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  syn_i,
  input  logic              par_err_i,
  input  logic              cor_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sec_o,
  output logic              ded_o
);

  localparam int unsigned CODE_N = DATA_W + CHK_W;

  logic [DATA_W-1:0] flip;
  logic              syn_nz;
  logic              in_range;

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam int unsigned POS = secded_pkg::data_pos(i);
    assign flip[i] = (syn_i == CHK_W'(POS));
  end

  assign syn_nz   = |syn_i;
  assign in_range = (32'(syn_i) <= CODE_N);

  // zero syndrome + parity fail: parity bit itself; check-bit positions flip nothing
  assign sec_o  = par_err_i & (~syn_nz | in_range);
  assign ded_o  = syn_nz & (~par_err_i | ~in_range);
  assign data_o = (cor_en_i && sec_o) ? (data_i ^ flip) : data_i;

  always_comb begin
    if (!$isunknown({syn_i, par_err_i})) begin
      assert ($onehot0(flip))     else $error("AST_ONE_FLIP");     // R5
      assert (!(sec_o && ded_o))  else $error("AST_FLAG_EXCL_C");  // R12
    end
  end

endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = secded_pkg::chk_width(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CHK_W-1:0]  enc_chk_o,
  output logic              enc_par_o,
  input  logic              dec_vld_i,
  input  logic [DATA_W-1:0] dec_data_i,
  input  logic [CHK_W-1:0]  dec_chk_i,
  input  logic              dec_par_i,
  input  logic              dec_cor_en_i,
  output logic              dec_vld_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dec_sec_o,
  output logic              dec_ded_o
);

  logic [CHK_W-1:0]  syn;
  logic              par_err;
  logic [DATA_W-1:0] fix_data;
  logic              fix_sec;
  logic              fix_ded;

  secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
    .data_i (enc_data_i),
    .chk_o  (enc_chk_o),
    .par_o  (enc_par_o)
  );

  secded_syn #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_syn (
    .data_i    (dec_data_i),
    .chk_i     (dec_chk_i),
    .par_i     (dec_par_i),
    .syn_o     (syn),
    .par_err_o (par_err)
  );

  secded_fix #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_fix (
    .data_i    (dec_data_i),
    .syn_i     (syn),
    .par_err_i (par_err),
    .cor_en_i  (dec_cor_en_i),
    .data_o    (fix_data),
    .sec_o     (fix_sec),
    .ded_o     (fix_ded)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_vld_o  <= 1'b0;
      dec_data_o <= '0;
      dec_sec_o  <= 1'b0;
      dec_ded_o  <= 1'b0;
    end else begin
      dec_vld_o <= dec_vld_i;
      if (dec_vld_i) begin
        dec_data_o <= fix_data;
        dec_sec_o  <= fix_sec;
        dec_ded_o  <= fix_ded;
      end
    end
  end

  AST_VLD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> dec_vld_o == $past(dec_vld_i)) else $error("AST_VLD_LATENCY"); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_vld_i |=> $stable(dec_data_o) && $stable(dec_sec_o) && $stable(dec_ded_o))
    else $error("AST_HOLD_IDLE"); // R10
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_sec_o && dec_ded_o)) else $error("AST_FLAG_EXCL"); // R12
  AST_DED_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_i && fix_ded |=> dec_ded_o && dec_data_o == $past(dec_data_i))
    else $error("AST_DED_RAW"); // R7
  AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_i && !dec_cor_en_i |=> dec_data_o == $past(dec_data_i))
    else $error("AST_BYPASS"); // R9
  AST_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_i && syn == '0 && !par_err |=> !dec_sec_o && !dec_ded_o)
    else $error("AST_CLEAN"); // R4

endmodule

// File: tb/secded_codec_bench.sv
module secded_codec_bench;

  localparam int unsigned DW = 64;
  localparam int unsigned CW = 7;
  localparam logic [7:0]  NO = 8'hFF;

  typedef struct packed {
    logic [63:0] d;
    logic [7:0]  f1;   // flip index: 0..63 data, 64..70 check, 71 parity
    logic [7:0]  f2;
    logic        cen;
    logic        esec;
    logic        eded;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{64'h0,                  NO,    NO,    1'b1, 1'b0, 1'b0}, // R4
    '{64'hDEADBEEF_01234567,  NO,    NO,    1'b1, 1'b0, 1'b0}, // R4
    '{64'hDEADBEEF_01234567,  8'd2,  NO,    1'b1, 1'b1, 1'b0}, // R5
    '{64'hA5A5_5A5A_F00F_0FF0, 8'd63, NO,   1'b1, 1'b1, 1'b0}, // R5
    '{64'hFFFF_FFFF_FFFF_FFFF, 8'd0, NO,    1'b1, 1'b1, 1'b0}, // R5
    '{64'h1357_9BDF_2468_ACE0, 8'd64, NO,   1'b1, 1'b1, 1'b0}, // R6
    '{64'h1357_9BDF_2468_ACE0, 8'd70, NO,   1'b1, 1'b1, 1'b0}, // R6
    '{64'h0F0F_0F0F_0F0F_0F0F, 8'd71, NO,   1'b1, 1'b1, 1'b0}, // R6
    '{64'hCAFE_F00D_8BAD_BEEF, 8'd2, 8'd5,  1'b1, 1'b0, 1'b1}, // R7
    '{64'hCAFE_F00D_8BAD_BEEF, 8'd0, 8'd70, 1'b1, 1'b0, 1'b1}, // R7
    '{64'h0123_4567_89AB_CDEF, 8'd10, NO,   1'b0, 1'b1, 1'b0}, // R9
    '{64'h0123_4567_89AB_CDEF, 8'd3, 8'd9,  1'b0, 1'b0, 1'b1}  // R9
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] enc_data = '0;
  logic [CW-1:0] enc_chk;
  logic          enc_par;
  logic          dvld = 1'b0;
  logic [DW-1:0] ddata = '0;
  logic [CW-1:0] dchk = '0;
  logic          dpar = 1'b0;
  logic          dcen = 1'b1;
  logic          ovld;
  logic [DW-1:0] odata;
  logic          osec;
  logic          oded;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  secded_codec #(.DATA_W(DW)) u_secded_codec (
    .clk_i(clk), .rst_ni(rst_n),
    .enc_data_i(enc_data), .enc_chk_o(enc_chk), .enc_par_o(enc_par),
    .dec_vld_i(dvld), .dec_data_i(ddata), .dec_chk_i(dchk), .dec_par_i(dpar),
    .dec_cor_en_i(dcen),
    .dec_vld_o(ovld), .dec_data_o(odata), .dec_sec_o(osec), .dec_ded_o(oded)
  );

  // reference: check bits = XOR of the positions of all set data bits
  function automatic logic [CW-1:0] ref_chk(logic [DW-1:0] d);
    logic [CW-1:0] acc;
    int p;
    int i;
    acc = '0;
    p = 0;
    i = 0;
    while (i < DW) begin
      p++;
      if ((p & (p - 1)) != 0) begin
        if (d[i]) acc ^= CW'(p);
        i++;
      end
    end
    return acc;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic decode(logic [DW-1:0] d, logic [CW-1:0] c, logic p, logic cen);
    @(negedge clk);
    ddata = d; dchk = c; dpar = p; dcen = cen; dvld = 1'b1;
    @(negedge clk);
    dvld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R11 reset state
    #3;
    check("R11", {ovld, osec, oded, odata}, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {ovld, osec, oded, odata}, '0);

    // R1 width
    check("R1", 128'($bits(enc_chk)), 128'd7);
    // R2 known positions: data bit 0 at 3, data bit 4 at 9
    enc_data = 64'h1; #1;
    check("R2", 128'(enc_chk), 128'h03);
    check("R3", 128'(enc_par), 128'h1);
    enc_data = 64'h10; #1;
    check("R2", 128'(enc_chk), 128'h09);
    enc_data = 64'h8000_0000_0000_0000; #1;
    check("R2", 128'(enc_chk), 128'h47);

    for (int k = 0; k < NV; k++) begin
      logic [DW-1:0] sd;
      logic [CW-1:0] sc;
      logic          sp;
      logic [71:0]   word;
      logic [DW-1:0] exp_d;
      enc_data = TBL[k].d; #1;
      check("R2", 128'(enc_chk), 128'(ref_chk(TBL[k].d)));
      check("R3", 128'(enc_par), 128'((^TBL[k].d) ^ (^ref_chk(TBL[k].d))));
      word = {enc_par, enc_chk, TBL[k].d};
      if (TBL[k].f1 != NO) word[TBL[k].f1] = ~word[TBL[k].f1];
      if (TBL[k].f2 != NO) word[TBL[k].f2] = ~word[TBL[k].f2];
      sd = word[63:0]; sc = word[70:64]; sp = word[71];
      exp_d = (TBL[k].cen && TBL[k].esec) ? TBL[k].d : sd;
      decode(sd, sc, sp, TBL[k].cen);
      check("R10", 128'(ovld), 128'h1);
      check(TBL[k].eded ? "R7" : (TBL[k].esec ? "R5/R6" : "R4"),
            {osec, oded}, {TBL[k].esec, TBL[k].eded});
      check(TBL[k].cen ? "R5" : "R9", 128'(odata), 128'(exp_d));
      check("R12", 128'(osec & oded), 128'h0);
    end

    // R8 all check bits flipped: syndrome 127 > 71, odd parity error
    enc_data = 64'h0055_AA00_FF00_33CC; #1;
    decode(enc_data, ~enc_chk, enc_par, 1'b1);
    check("R8", {osec, oded}, 2'b01);
    check("R8", 128'(odata), 128'(enc_data));

    // R10 hold while idle, valid drops
    @(negedge clk);
    ddata = 64'h1111; dchk = '1; dpar = 1'b0; dvld = 1'b0;
    @(negedge clk);
    check("R10", 128'(ovld), 128'h0);
    check("R10", {osec, oded, odata}, {2'b01, 64'h0055_AA00_FF00_33CC});

    // R7 named case: data bits 2 and 5, correction on, output must stay raw
    enc_data = 64'h0; #1;
    decode(64'h24, enc_chk, enc_par, 1'b1);
    check("R7", {osec, oded, odata}, {2'b01, 64'h24});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule